// File: doc/BRIEF.md
# Tile Rotator and Morton Swizzler

This block collects a raster pixel stream eight lines at a time and then emits the result as a sequence of 8x8 pixel tiles. The tiles are produced left to right across each buffered strip. Each tile can be turned by a quarter, half or three-quarter clockwise turn. The pixels inside a tile can leave in plain raster order or in Z-order (Morton) sequence. A downstream writer that fills memory in tiled layout uses it.

There are two strip buffers that alternate. One fills from the input while the other drains to the output. The input stops accepting only when both buffers hold complete strips. The input carries a start-of-frame marker, which restarts the strip being filled, and an end-of-line marker, which closes the current line. The output uses a valid/ready handshake and flags the last pixel of every tile.

Top module: `tile_reorder`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: A line is closed by a pixel accepted with in_eol high. out_valid rises in the cycle after the end-of-line pixel of the eighth line is accepted, and not before, when no other strip is waiting.
- R3: Each tile is exactly 64 output pixels. out_last is high on the 64th of them only. Tile t of a strip covers source columns 8t to 8t+7, and tiles leave in increasing t.
- R4: With cfg_rot = 0 and cfg_morton = 0, output index k (0..63) within a tile takes the source pixel at x = k mod 8 (column), y = k div 8 (line).
- R5: cfg_rot selects a clockwise turn of the tile. For output position (x, y), the source pixel is (x, y) for code 0, (y, 7-x) for code 1 (90 degrees), (7-x, 7-y) for code 2 (180 degrees), and (7-y, x) for code 3 (270 degrees).
- R6: With cfg_morton = 1, the output position of index k is x = {k[4], k[2], k[0]} and y = {k[5], k[3], k[1]}. The R5 rotation is then applied to that position to find the source pixel.
- R7: A second strip is accepted while the first drains. in_ready goes low only when both strip buffers hold complete, undrained strips.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last stay unchanged.
- R9: A pixel accepted with in_sof high is stored at line 0, column 0 of the strip being filled. Any partial lines gathered before it are discarded.
- R10: cfg_tiles (1..MAX_TILES) sets the tiles per strip. Accepted pixels at columns 8*cfg_tiles and above on a line never reach the output. The cfg inputs must stay fixed while any strip is buffered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tiles | input | $clog2(MAX_TILES+1) | Tiles per strip (line width / 8) |
| cfg_rot | input | 2 | Tile rotation code |
| cfg_morton | input | 1 | Z-order readout inside a tile |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel can be accepted |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel taken |
| out_data | output | PIX_W | Output pixel |
| out_last | output | 1 | Last pixel of a tile |

## Verification
The assertions check the following properties on every cycle:
- the output holds steady under backpressure;
- input is refused whenever both strip buffers are full;
- nothing is written into a buffer that is still awaiting readout;
- a finished strip marks its buffer full;
- the tile-end flag lands on every 64th accepted beat.

The mapping from output index to source pixel for each rotation and Morton setting can only be shown by the bench's scenarios, which compare every emitted pixel with an independently computed value. The same holds for these behaviours:
- discarding of columns beyond the programmed width;
- the restart on a frame marker;
- when the first strip becomes visible.

// File: rtl/tr_pkg.sv
package tr_pkg;

    localparam int TILE_DIM = 8;
    localparam int TILE_PIX = TILE_DIM * TILE_DIM;

    typedef logic [2:0] coord_t;
    typedef logic [5:0] tidx_t;

    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_e;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } xy_t;

    // Output position of tile index k: raster or Z-order.
    function automatic xy_t idx_to_pos(tidx_t k, logic morton);
        xy_t p;
        if (morton) begin
            p.x = {k[4], k[2], k[0]};
            p.y = {k[5], k[3], k[1]};
        end else begin
            p.x = k[2:0];
            p.y = k[5:3];
        end
        return p;
    endfunction

    // Source pixel feeding output position o for a clockwise turn r.
    function automatic xy_t rotate_src(xy_t o, rot_e r);
        xy_t s;
        case (r)
            ROT_90: begin
                s.x = o.y;
                s.y = 3'd7 - o.x;
            end
            ROT_180: begin
                s.x = 3'd7 - o.x;
                s.y = 3'd7 - o.y;
            end
            ROT_270: begin
                s.x = 3'd7 - o.y;
                s.y = o.x;
            end
            default: s = o;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tr_fill.sv
module tr_fill #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    input  logic [1:0]    bank_full,
    output logic          in_ready,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [2:0]    wr_line,
    output logic [CW-1:0] wr_col,
    output logic          strip_done
);
    localparam int CNT_W = CW + 1;

    logic             bank_q;
    logic [2:0]       line_q;
    logic [CNT_W-1:0] col_q;
    logic             accept;
    logic [2:0]       eff_line;
    logic [CNT_W-1:0] eff_col;

    always_comb begin
        in_ready   = !bank_full[bank_q];
        accept     = in_valid && in_ready;
        eff_line   = in_sof ? 3'd0 : line_q;
        eff_col    = in_sof ? '0 : col_q;
        wr_en      = accept && !eff_col[CW];
        wr_bank    = bank_q;
        wr_line    = eff_line;
        wr_col     = eff_col[CW-1:0];
        strip_done = accept && in_eol && (eff_line == 3'd7);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= 1'b0;
            line_q <= '0;
            col_q  <= '0;
        end else if (accept) begin
            if (in_eol) begin
                col_q <= '0;
                if (eff_line == 3'd7) begin
                    line_q <= '0;
                    bank_q <= !bank_q;
                end else begin
                    line_q <= eff_line + 3'd1;
                end
            end else begin
                line_q <= eff_line;
                col_q  <= eff_col[CW] ? eff_col : eff_col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tr_drain.sv
module tr_drain
    import tr_pkg::*;
#(
    parameter int MAX_TILES = 8,
    parameter int TIDX_W    = 3,
    parameter int CFG_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_tiles,
    input  logic [1:0]        cfg_rot,
    input  logic              cfg_morton,
    input  logic [1:0]        bank_full,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic              rd_bank,
    output logic [2:0]        rd_line,
    output logic [TIDX_W+2:0] rd_col,
    output logic              strip_free
);
    tidx_t             k_q;
    logic [TIDX_W-1:0] tile_q;
    logic              bank_q;
    logic              fire;
    logic              tile_end;
    logic              last_tile;
    xy_t               out_pos;
    xy_t               src_pos;

    always_comb begin
        out_valid  = bank_full[bank_q];
        fire       = out_valid && out_ready;
        tile_end   = (k_q == tidx_t'(TILE_PIX - 1));
        last_tile  = (CFG_W'(tile_q) + CFG_W'(1)) >= cfg_tiles;
        out_pos    = idx_to_pos(k_q, cfg_morton);
        src_pos    = rotate_src(out_pos, rot_e'(cfg_rot));
        rd_bank    = bank_q;
        rd_line    = src_pos.y;
        rd_col     = {tile_q, src_pos.x};
        out_last   = out_valid && tile_end;
        strip_free = fire && tile_end && last_tile;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q    <= '0;
            tile_q <= '0;
            bank_q <= 1'b0;
        end else if (fire) begin
            k_q <= k_q + 1'b1;
            if (tile_end) begin
                if (last_tile) begin
                    tile_q <= '0;
                    bank_q <= !bank_q;
                end else begin
                    tile_q <= tile_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tile_reorder.sv
module tile_reorder
    import tr_pkg::*;
#(
    parameter int PIX_W     = 16,
    parameter int MAX_TILES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(MAX_TILES+1)-1:0] cfg_tiles,
    input  logic [1:0]                     cfg_rot,
    input  logic                           cfg_morton,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [PIX_W-1:0]               in_data,
    input  logic                           in_sof,
    input  logic                           in_eol,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [PIX_W-1:0]               out_data,
    output logic                           out_last
);
    localparam int TIDX_W = $clog2(MAX_TILES);
    localparam int CFG_W  = $clog2(MAX_TILES + 1);
    localparam int CW     = TIDX_W + 3;
    localparam int AW     = 1 + 3 + CW;
    localparam int DEPTH  = 1 << AW;

    logic [1:0]       bank_full;
    logic             wr_en;
    logic             wr_bank;
    logic [2:0]       wr_line;
    logic [CW-1:0]    wr_col;
    logic             strip_done;
    logic             rd_bank;
    logic [2:0]       rd_line;
    logic [CW-1:0]    rd_col;
    logic             strip_free;
    logic [PIX_W-1:0] mem [DEPTH];

    tr_fill #(.CW(CW)) fill_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .bank_full  (bank_full),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_line    (wr_line),
        .wr_col     (wr_col),
        .strip_done (strip_done)
    );

    tr_drain #(.MAX_TILES(MAX_TILES), .TIDX_W(TIDX_W), .CFG_W(CFG_W)) drain_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_tiles  (cfg_tiles),
        .cfg_rot    (cfg_rot),
        .cfg_morton (cfg_morton),
        .bank_full  (bank_full),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .rd_bank    (rd_bank),
        .rd_line    (rd_line),
        .rd_col     (rd_col),
        .strip_free (strip_free)
    );

    // The filler only completes a non-full bank; the drainer only frees a full one.
    always_ff @(posedge clk) begin
        if (rst) begin
            bank_full <= '0;
        end else begin
            if (strip_done) bank_full[wr_bank] <= 1'b1;
            if (strip_free) bank_full[rd_bank] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_bank, wr_line, wr_col}] <= in_data;
    end

    assign out_data = mem[{rd_bank, rd_line, rd_col}];

endmodule

// File: rtl/tr_checker.sv
module tr_checker #(
    parameter int PIX_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_last,
    input logic [1:0]       bank_full,
    input logic             wr_en,
    input logic             wr_bank,
    input logic             strip_done
);
    logic [5:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) beat_cnt <= '0;
        else if (out_valid && out_ready) beat_cnt <= beat_cnt + 1'b1;
    end

    // R8: stalled output holds
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R7: both buffers full refuses input
    a_r7_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        bank_full == 2'b11 |-> !in_ready);

    // R7: no write into a buffer awaiting readout
    a_r7_no_write_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bank_full[wr_bank]);

    // R2: a completed strip marks its buffer full
    a_r2_strip_marks_full: assert property (@(posedge clk) disable iff (rst)
        strip_done |=> bank_full[$past(wr_bank)]);

    // R3: tile end lands on the 64th beat
    a_r3_tile_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> beat_cnt == 6'd63);

endmodule

bind tile_reorder tr_checker #(.PIX_W(PIX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .bank_full  (bank_full),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .strip_done (strip_done)
);

// File: tb/tile_reorder_tb_top.sv
module tile_reorder_tb_top;
    localparam int PIX_W     = 16;
    localparam int MAX_TILES = 8;
    localparam int CFG_W     = $clog2(MAX_TILES + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CFG_W-1:0] cfg_tiles = 4'd1;
    logic [1:0]       cfg_rot = 2'd0;
    logic             cfg_morton = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_data = '0;
    logic             in_sof = 1'b0;
    logic             in_eol = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PIX_W-1:0] out_data;
    logic             out_last;

    int n_checks = 0;
    int n_errors = 0;
    bit timed_out = 0;
    int sent = 0;
    logic [16:0] exp_q[$];

    always #5 clk = ~clk;

    tile_reorder #(.PIX_W(PIX_W), .MAX_TILES(MAX_TILES)) dut_i (
        .clk(clk), .rst(rst), .cfg_tiles(cfg_tiles), .cfg_rot(cfg_rot),
        .cfg_morton(cfg_morton), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    initial begin
        repeat (190000) @(posedge clk);
        timed_out = 1;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(int s, int line, int col);
        return {s[5:0], line[2:0], col[6:0]};
    endfunction

    // Expected tile stream of one strip, from R3..R6
    function automatic void plan_strip(int s, int tiles, int rot, bit mort);
        for (int t = 0; t < tiles; t++) begin
            for (int k = 0; k < 64; k++) begin
                int ox, oy, sx, sy;
                if (mort) begin
                    ox = ((k >> 4) & 1) * 4 + ((k >> 2) & 1) * 2 + (k & 1);
                    oy = ((k >> 5) & 1) * 4 + ((k >> 3) & 1) * 2 + ((k >> 1) & 1);
                end else begin
                    ox = k % 8;
                    oy = k / 8;
                end
                case (rot)
                    1: begin sx = oy;     sy = 7 - ox; end
                    2: begin sx = 7 - ox; sy = 7 - oy; end
                    3: begin sx = 7 - oy; sy = ox;     end
                    default: begin sx = ox; sy = oy; end
                endcase
                exp_q.push_back({k == 63, enc(s, sy, t * 8 + sx)});
            end
        end
    endfunction

    task automatic push(logic [15:0] d, bit sof, bit eol);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eol = eol;
        while (!in_ready && !timed_out) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        if ($urandom % 4 == 0) @(negedge clk);
    endtask

    task automatic send_strip(int s, int tiles, int extra, bit first);
        int w = tiles * 8 + extra;
        for (int line = 0; line < 8; line++) begin
            for (int col = 0; col < w; col++) begin
                bit last = (line == 7) && (col == w - 1);
                if (first && last) check(out_valid == 1'b0, "R2", "valid before strip end", out_valid, 0);
                push(enc(s, line, col), first && line == 0 && col == 0, col == w - 1);
                if (first && last) check(out_valid == 1'b1, "R2", "valid after strip end", out_valid, 1);
            end
        end
        sent++;
    endtask

    task automatic drain(int n, string req);
        int got = 0;
        bit stalled = 0;
        logic [15:0] held = '0;
        while (got < n && !timed_out) begin
            @(negedge clk);
            if (stalled) check(out_valid && out_data == held, "R8", "held data", out_data, held);
            stalled = 0;
            out_ready = ($urandom % 4) != 0;
            if (out_valid) begin
                if (out_ready) begin
                    logic [16:0] e = exp_q.pop_front();
                    check(out_data == e[15:0], req, "pixel", out_data, e[15:0]);
                    check(out_last == e[16], "R3", "tile end flag", out_last, e[16]);
                    got++;
                end else begin
                    stalled = 1;
                    held = out_data;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_frame(int tiles, int rot, bit mort, int nstr, int extra, int s0, string req);
        cfg_tiles = CFG_W'(tiles); cfg_rot = rot[1:0]; cfg_morton = mort;
        for (int i = 0; i < nstr; i++) plan_strip(s0 + i, tiles, rot, mort);
        fork
            for (int i = 0; i < nstr; i++) send_strip(s0 + i, tiles, extra, i == 0);
            drain(nstr * tiles * 64, req);
        join
        repeat (20) @(negedge clk);
        check(out_valid == 1'b0, "R10", "no extra output", out_valid, 0);
        check(in_ready == 1'b1, "R7", "ready when idle", in_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);

        // R7: ping-pong with the output stalled
        cfg_tiles = 4'd1; cfg_rot = 2'd0; cfg_morton = 1'b0;
        for (int i = 0; i < 3; i++) plan_strip(1 + i, 1, 0, 0);
        sent = 0;
        fork
            for (int i = 0; i < 3; i++) send_strip(1 + i, 1, 0, i == 0);
            begin
                while (sent < 2 && !timed_out) @(negedge clk);
                repeat (10) @(negedge clk);
                check(in_ready == 1'b0, "R7", "stall with two full strips", in_ready, 0);
                check(out_valid == 1'b1, "R7", "first strip waiting", out_valid, 1);
                drain(3 * 64, "R7");
            end
        join
        repeat (10) @(negedge clk);

        // R9: partial garbage then a frame restart
        cfg_tiles = 4'd1;
        for (int line = 0; line < 3; line++)
            for (int col = 0; col < 8; col++)
                push(enc(63, line, col), line == 0 && col == 0, col == 7);
        for (int col = 0; col < 5; col++) push(enc(62, 3, col), 1'b0, 1'b0);
        plan_strip(5, 1, 0, 0);
        fork
            send_strip(5, 1, 0, 1'b1);
            drain(64, "R9");
        join

        // R10: pixels past the programmed width are dropped
        run_frame(2, 0, 0, 1, 16, 6, "R10");

        // R4, R5, R6: every rotation with and without Z-order
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 2; m++)
                run_frame(2, r, m[0], 1, 0, 8 + r * 2 + m,
                          m ? "R6" : (r == 0 ? "R4" : "R5"));

        // Random frames
        for (int f = 0; f < 10 && !timed_out; f++) begin
            int tiles = 1 + $urandom % MAX_TILES;
            int rot   = $urandom % 4;
            bit mort  = $urandom % 2;
            int nstr  = 1 + $urandom % 3;
            int extra = (tiles < MAX_TILES) ? 8 * ($urandom % (MAX_TILES - tiles + 1)) : 0;
            run_frame(tiles, rot, mort, nstr, extra, 20 + f * 3,
                      mort ? "R6" : (rot == 0 ? "R4" : "R5"));
        end

        check(!timed_out, "R3", "watchdog", timed_out, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule